// File: doc/BRIEF.md
# Slot Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and a larger physical memory. It cuts the CPU's 64k space into four 16k slots and holds one bank register per slot. The top two CPU address bits pick a slot. That slot's register supplies the upper physical address bits and decides whether the access goes to RAM or to ROM. Because of this, ROM banks are mapped in exactly the same way as RAM banks.

The four registers sit in a 16-byte I/O window at $0200 to $020F. Software writes them at run time to remap memory. Nothing stops the same bank from appearing in several slots. The rest of the window is handed to other peripherals through an external I/O select. Reset leaves ROM bank 0 in the top slot so that the CPU fetches its reset vector from ROM.

Top module: `mmu_slot_mapper`

## Requirements
- R1: CPU address bits 15:14 select the slot. CPU address bits 13:0 appear unchanged on `mem_addr[13:0]`.
- R2: Outside the I/O window, `mem_addr[18:14]` equals bits 4:0 of the selected slot's register.
- R3: Outside the window, register bit 7 = 1 asserts `rom_cs` and bit 7 = 0 asserts `ram_cs`. In every cycle exactly one of `ram_cs`, `rom_cs` and `io_cs` is high.
- R4: After reset the slot registers hold $00, $01, $02 and $80 for slots 0 to 3. Slot 3 therefore maps ROM bank 0.
- R5: Addresses $0200 to $020F assert `io_cs` and keep `ram_cs`, `rom_cs` and `mem_we` low. A cycle with `cpu_we` = 1 at offset n (0 to 3) loads `cpu_wdata` into slot n's register at that clock edge.
- R6: `cfg_rdata` returns slot n's register while the address is $0200+n (n = 0 to 3). At every other address it is $00.
- R7: Offsets 4 to 15 of the window assert `ext_io_cs`. Offsets 0 to 3 and all addresses outside the window keep it low. Writes at offsets 4 to 15 leave all slot registers unchanged.
- R8: `mem_we` is high only when `ram_cs` and `cpu_we` are both high. An access that goes to ROM never asserts it.
- R9: Register bits 6 and 5 are stored and read back but do not change `mem_addr`, `ram_cs` or `rom_cs`.
- R10: One bank may be mapped into several slots at once, including all four, and each of those slots translates to it.
- R11: During the cycle that writes a register, every output still reflects the old register value. `cfg_rdata` shows the old contents, and the new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_wdata | input | 8 | CPU write data |
| cfg_rdata | output | 8 | Bank register readback |
| mem_addr | output | 19 | Physical address to RAM and ROM |
| ram_cs | output | 1 | RAM chip select |
| rom_cs | output | 1 | ROM chip select |
| io_cs | output | 1 | I/O window select |
| ext_io_cs | output | 1 | Select for peripherals at window offsets 4 to 15 |
| mem_we | output | 1 | Gated memory write enable |

## Verification
The bench first replays a boot sequence: ROM starts in slot 3, RAM bank 3 is staged through slot 2, and then slot 3 is switched to bank 3. This shows that remapping a slot changes only that slot's translation. It then maps one bank into all four slots, and it sets the reserved bits, which must come back on readback and must not move the physical address. It also writes to the peripheral offsets and checks that no register changes, and it reads a register in the very cycle that writes it, which separates an update at the next edge from a same-cycle one. Finally a long stream of random addresses, with a quarter of them aimed at the window and random write strobes, is compared every cycle against a behavioural model. This catches slot-index, RAM/ROM polarity and write-gating errors.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_ROM = 2'd1,
    TGT_IO  = 2'd2
  } tgt_e;

  // Reset value of a slot: the top slot maps ROM bank 0 and the other slots map RAM bank = slot index.
  function automatic int slot_reset_value(int idx, int nslots, int rom_bit);
    return (idx == nslots - 1) ? (1 << rom_bit) : idx;
  endfunction

endpackage

// File: rtl/mmu_bank_regs.sv
module mmu_bank_regs #(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 8,
  parameter int ROM_BIT   = 7,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] regs_q
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [DATA_W-1:0] RST_VAL =
      DATA_W'(mmu_pkg::slot_reset_value(g, NUM_SLOTS, ROM_BIT));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= RST_VAL;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        regs_q[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate #(
  parameter int ADDR_W    = 16,
  parameter int SLOT_BITS = 2,
  parameter int BANK_BITS = 5,
  parameter int DATA_W    = 8,
  parameter int ROM_BIT   = 7,
  localparam int NUM_SLOTS = 1 << SLOT_BITS,
  localparam int OFF_W     = ADDR_W - SLOT_BITS,
  localparam int PHYS_W    = OFF_W + BANK_BITS
) (
  input  logic [ADDR_W-1:0]                cpu_addr,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] regs,
  output logic [SLOT_BITS-1:0]             slot_idx,
  output logic                             slot_rom,
  output logic [PHYS_W-1:0]                phys_addr
);

  function automatic logic [PHYS_W-1:0] make_phys(
    input logic [DATA_W-1:0] bank_reg,
    input logic [ADDR_W-1:0] addr
  );
    return {bank_reg[BANK_BITS-1:0], addr[OFF_W-1:0]};
  endfunction

  logic [DATA_W-1:0] sel_reg;

  always_comb begin
    slot_idx  = cpu_addr[ADDR_W-1 -: SLOT_BITS];
    sel_reg   = regs[slot_idx];
    slot_rom  = sel_reg[ROM_BIT];
    phys_addr = make_phys(sel_reg, cpu_addr);
  end

endmodule

// File: rtl/mmu_decode.sv
module mmu_decode #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_SLOTS = 4,
  parameter int IO_LOG2   = 4,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'h0200,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [ADDR_W-1:0]                cpu_addr,
  input  logic                             cpu_we,
  input  logic                             slot_rom,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] regs,
  output mmu_pkg::tgt_e                    tgt,
  output logic                             ram_cs,
  output logic                             rom_cs,
  output logic                             io_cs,
  output logic                             ext_io_cs,
  output logic                             mem_we,
  output logic                             reg_wr,
  output logic [IDX_W-1:0]                 reg_idx,
  output logic [DATA_W-1:0]                cfg_rdata
);

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IO_LOG2] == IO_BASE[ADDR_W-1:IO_LOG2];
  endfunction

  logic               win_hit;
  logic               reg_hit;
  logic [IO_LOG2-1:0] win_off;

  always_comb begin
    win_hit = in_window(cpu_addr);
    win_off = cpu_addr[IO_LOG2-1:0];
    reg_hit = win_hit && (32'(win_off) < NUM_SLOTS);
    reg_idx = win_off[IDX_W-1:0];

    if (win_hit)       tgt = mmu_pkg::TGT_IO;
    else if (slot_rom) tgt = mmu_pkg::TGT_ROM;
    else               tgt = mmu_pkg::TGT_RAM;

    ram_cs    = (tgt == mmu_pkg::TGT_RAM);
    rom_cs    = (tgt == mmu_pkg::TGT_ROM);
    io_cs     = (tgt == mmu_pkg::TGT_IO);
    ext_io_cs = win_hit && !reg_hit;
    mem_we    = ram_cs && cpu_we;
    reg_wr    = reg_hit && cpu_we;
    cfg_rdata = reg_hit ? regs[reg_idx] : '0;
  end

endmodule

// File: rtl/mmu_slot_mapper.sv
module mmu_slot_mapper #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SLOT_BITS = 2,
  parameter int BANK_BITS = 5,
  parameter int ROM_BIT   = 7,
  parameter int IO_LOG2   = 4,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'h0200,
  localparam int NUM_SLOTS = 1 << SLOT_BITS,
  localparam int IDX_W     = SLOT_BITS,
  localparam int PHYS_W    = ADDR_W - SLOT_BITS + BANK_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              ram_cs,
  output logic              rom_cs,
  output logic              io_cs,
  output logic              ext_io_cs,
  output logic              mem_we
);

  // Internal events, named for the bound checker
  logic [NUM_SLOTS-1:0][DATA_W-1:0] regs_q;
  logic                             reg_wr;
  logic [IDX_W-1:0]                 reg_idx;
  logic [SLOT_BITS-1:0]             slot_idx;
  logic                             slot_rom;
  mmu_pkg::tgt_e                    tgt;

  mmu_bank_regs #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .ROM_BIT   (ROM_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_idx  (reg_idx),
    .wr_data (cpu_wdata),
    .regs_q  (regs_q)
  );

  mmu_xlate #(
    .ADDR_W    (ADDR_W),
    .SLOT_BITS (SLOT_BITS),
    .BANK_BITS (BANK_BITS),
    .DATA_W    (DATA_W),
    .ROM_BIT   (ROM_BIT)
  ) u_xlate (
    .cpu_addr  (cpu_addr),
    .regs      (regs_q),
    .slot_idx  (slot_idx),
    .slot_rom  (slot_rom),
    .phys_addr (mem_addr)
  );

  mmu_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_SLOTS (NUM_SLOTS),
    .IO_LOG2   (IO_LOG2),
    .IO_BASE   (IO_BASE)
  ) u_decode (
    .cpu_addr  (cpu_addr),
    .cpu_we    (cpu_we),
    .slot_rom  (slot_rom),
    .regs      (regs_q),
    .tgt       (tgt),
    .ram_cs    (ram_cs),
    .rom_cs    (rom_cs),
    .io_cs     (io_cs),
    .ext_io_cs (ext_io_cs),
    .mem_we    (mem_we),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .cfg_rdata (cfg_rdata)
  );

endmodule

// File: rtl/mmu_slot_mapper_chk.sv
module mmu_slot_mapper_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2,
  parameter int PHYS_W    = 19,
  parameter int OFF_W     = 14
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [ADDR_W-1:0]                cpu_addr,
  input logic                             cpu_we,
  input logic [DATA_W-1:0]                cpu_wdata,
  input logic [DATA_W-1:0]                cfg_rdata,
  input logic [PHYS_W-1:0]                mem_addr,
  input logic                             ram_cs,
  input logic                             rom_cs,
  input logic                             io_cs,
  input logic                             ext_io_cs,
  input logic                             mem_we,
  input logic                             reg_wr,
  input logic [IDX_W-1:0]                 reg_idx,
  input logic [NUM_SLOTS-1:0][DATA_W-1:0] regs_q
);

  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_cs, rom_cs, io_cs}) == 1);

  a_r1_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !io_cs |-> mem_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

  a_r5_window_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    io_cs |-> !mem_we);

  a_r8_rom_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> !mem_we);

  a_r8_we_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cpu_we && ram_cs));

  a_r7_ext_not_reg: assert property (@(posedge clk) disable iff (!rst_n)
    ext_io_cs |-> (io_cs && !reg_wr));

  a_r7_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(regs_q));

  a_r11_old_readback: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> cfg_rdata == regs_q[reg_idx]);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_upd
    a_r5_reg_update: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_idx == IDX_W'(k)) |=> regs_q[k] == $past(cpu_wdata));
  end

endmodule

bind mmu_slot_mapper mmu_slot_mapper_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_SLOTS (NUM_SLOTS),
  .IDX_W     (IDX_W),
  .PHYS_W    (PHYS_W),
  .OFF_W     (ADDR_W - SLOT_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_we    (cpu_we),
  .cpu_wdata (cpu_wdata),
  .cfg_rdata (cfg_rdata),
  .mem_addr  (mem_addr),
  .ram_cs    (ram_cs),
  .rom_cs    (rom_cs),
  .io_cs     (io_cs),
  .ext_io_cs (ext_io_cs),
  .mem_we    (mem_we),
  .reg_wr    (reg_wr),
  .reg_idx   (reg_idx),
  .regs_q    (regs_q)
);

// File: tb/tb_mmu_slot_mapper.sv
`timescale 1ns/1ps
module tb_mmu_slot_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [18:0] mem_addr;
  logic        ram_cs, rom_cs, io_cs, ext_io_cs, mem_we;

  always #2.5 clk = ~clk;

  mmu_slot_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .ram_cs(ram_cs), .rom_cs(rom_cs), .io_cs(io_cs),
    .ext_io_cs(ext_io_cs), .mem_we(mem_we)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  int unsigned mreg [4];   // behavioural model of the slot registers

  task automatic chk(string req, int unsigned act, int unsigned exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at time %0t", req, act, exp, $time);
    end
  endtask

  // Apply one access at the falling edge, compare the settled outputs with the model, then let the edge commit.
  task automatic step(input logic [15:0] a, input logic we, input logic [7:0] d, input string tag);
    bit win;
    int unsigned off, slot, r;
    cpu_addr = a; cpu_we = we; cpu_wdata = d;
    #1;
    win  = (a >> 4) == 16'h020;
    off  = a & 16'hF;
    slot = a >> 14;
    r    = mreg[slot];
    if (win) begin
      chk({"R5 io_cs ", tag}, io_cs, 1);
      chk({"R5 ram/rom ", tag}, {ram_cs, rom_cs}, 0);
      chk({"R5 mem_we ", tag}, mem_we, 0);
      chk({"R7 ext_io_cs ", tag}, ext_io_cs, off >= 4);
      chk({"R6 cfg_rdata ", tag}, cfg_rdata, off < 4 ? mreg[off] : 0);
    end else begin
      chk({"R3 rom_cs ", tag}, rom_cs, (r >> 7) & 1);
      chk({"R3 ram_cs ", tag}, ram_cs, ((r >> 7) & 1) == 0);
      chk({"R3 io_cs ", tag}, io_cs, 0);
      chk({"R7 ext_io_cs ", tag}, ext_io_cs, 0);
      chk({"R1 offset ", tag}, mem_addr & 19'h3FFF, a & 16'h3FFF);
      chk({"R2 bank ", tag}, mem_addr >> 14, r & 32'h1F);
      chk({"R8 mem_we ", tag}, mem_we, we && ((r >> 7) & 1) == 0);
      chk({"R6 cfg_rdata ", tag}, cfg_rdata, 0);
    end
    @(posedge clk);
    if (win && we && off < 4) mreg[off] = d;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    mreg[0] = 8'h00; mreg[1] = 8'h01; mreg[2] = 8'h02; mreg[3] = 8'h80;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: reset state through readback and through each slot
    for (int i = 0; i < 4; i++) step(16'h0200 + 16'(i), 1'b0, 8'h00, "R4 readback");
    step(16'h1234, 1'b0, 8'h00, "R4 slot0");
    step(16'h5678, 1'b0, 8'h00, "R4 slot1");
    step(16'h9ABC, 1'b0, 8'h00, "R4 slot2");
    step(16'hFFFC, 1'b0, 8'h00, "R4 slot3 vector");
    step(16'hFFFC, 1'b1, 8'h55, "R8 rom write blocked");

    // Boot sequence: stage RAM bank 3 via slot 2, then move slot 3 onto it
    step(16'h0202, 1'b1, 8'h03, "R11 write slot2");
    step(16'h0202, 1'b0, 8'h00, "R5 slot2 readback");
    step(16'h8000, 1'b1, 8'hA9, "R8 ram write");
    step(16'h0203, 1'b1, 8'h03, "R11 write slot3");
    step(16'hFFFC, 1'b0, 8'h00, "R2 slot3 now ram bank3");
    step(16'h1000, 1'b0, 8'h00, "R2 slot0 unchanged");

    // R10: same bank in all slots
    for (int i = 0; i < 4; i++) step(16'h0200 + 16'(i), 1'b1, 8'h9E, "R10 map all");
    for (int i = 0; i < 4; i++) step(16'(i) << 14 | 16'h0123, 1'b0, 8'h00, "R10 shared bank");

    // R9: reserved bits stored and read back, no effect on mapping
    step(16'h0201, 1'b1, 8'h65, "R9 write");
    step(16'h0201, 1'b0, 8'h00, "R9 readback");
    step(16'h4ABC, 1'b1, 8'h11, "R9 translate");

    // R7: peripheral offsets do not touch the registers
    for (int i = 4; i < 16; i++) step(16'h0200 + 16'(i), 1'b1, 8'hFF, "R7 ext write");
    for (int i = 0; i < 4; i++) step(16'h0200 + 16'(i), 1'b0, 8'h00, "R7 regs kept");

    // R11: back-to-back writes to one register, old value seen in each write cycle
    step(16'h0200, 1'b1, 8'h07, "R11 first");
    step(16'h0200, 1'b1, 8'h88, "R11 second");
    step(16'h2000, 1'b0, 8'h00, "R11 new rom map");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if (($urandom % 4) == 0) a = 16'h0200 | 16'($urandom % 16);
      step(a, 1'($urandom), 8'($urandom), "random");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule